// File: doc/BRIEF.md
# Programmable-Width Memory Bus Bridge

This block sits between a 32-bit processor request port and an external bus whose regions may be 8, 16 or 32 bits wide. Each request is matched against four region descriptors on the top address bits. The descriptor gives the port width and the wait states per beat. A request is then issued as one or more bus beats. On reads the returned bytes are gathered back into a 32-bit word, and on writes the bytes are routed onto the bus lanes.

Both single-word requests and fixed four-word read bursts are handled. Byte ordering on the bus can be switched between little- and big-endian. After a read, a programmable number of idle bus cycles is placed in front of a transaction that is a write or that targets a different descriptor. During that gap no address is driven.

Top module: `pwbus_bridge`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: Descriptor i matches when req_addr[31:28] equals cfg_tag[4i+3:4i]. When several descriptors match, the lowest index wins. An address that matches none is handled as a 32-bit port with zero wait states, and it counts as a descriptor of its own.
- R3: Width code cfg_width[2i+1:2i] selects the port: 0 is 8-bit, 1 is 16-bit, 2 or 3 is 32-bit. A full word takes 4 beats on an 8-bit port, 2 beats on a 16-bit port and 1 beat on a 32-bit port. Beat addresses start at the word address and step by the port width in bytes.
- R4: Only the beats that cover at least one enabled byte of req_be are issued, in ascending address order. bus_be marks exactly the enabled bytes of that beat.
- R5: An N-byte port uses bus lanes 0..N-1. A byte at offset o within the port goes on lane o when little-endian and on lane N-1-o when big-endian. The byte at word offset k is req_wdata/rsp_rdata bits [8k+7:8k] when little-endian and bits [8(3-k)+7:8(3-k)] when big-endian.
- R6: A write beat places each enabled byte on its lane and drives zero on all other lanes of bus_wdata.
- R7: A read response holds the returned enabled bytes at their word positions and zero elsewhere. A write response carries zero. rsp_valid is high for one cycle, in the cycle after the word's final beat.
- R8: Every beat lasts (wait+1) cycles. For the whole beat, bus_addr, bus_be, bus_write and bus_wdata hold steady.
- R9: A burst request reads four consecutive words from the word-aligned address, with all four bytes enabled whatever req_be and req_write say. It gives one rsp_valid pulse per word, in address order.
- R10: If the previous transaction was a read and the new one is a write or targets another descriptor, cfg_turn idle cycles with bus_valid low come before the first beat. Otherwise the first beat starts in the cycle after acceptance.
- R11: req_ready is high only when no transaction is in progress, so it is high in the cycle that carries the final rsp_valid. A request offered in that cycle is accepted at the next edge.
- R12: cfg_bigend=1 selects big-endian lane and word-byte ordering, and 0 selects little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Four-word read burst |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables, bit k = word offset k |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse per word |
| rsp_rdata | output | 32 | Assembled read word (zero for writes) |
| cfg_tag | input | 16 | Four 4-bit address tags |
| cfg_width | input | 8 | Four 2-bit width codes |
| cfg_wait | input | 12 | Four 3-bit wait-state counts |
| cfg_turn | input | 4 | Idle cycles after a read |
| cfg_bigend | input | 1 | Byte ordering select |
| bus_valid | output | 1 | Beat address phase active |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | 32 | Beat byte address |
| bus_be | output | 4 | Active lanes |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data, sampled on the beat's last cycle |

## Verification
The final response pulse of one transaction falls in the same cycle as the acceptance of the next one. Every test step issues its next request in the very cycle the previous rsp_valid is expected, and it checks that req_ready is already high there. Inside a burst on a zero-wait port, the response pulse of one word also shares a cycle with the first beat of the following word. The bench model expects both the pulse and the beat in that cycle and compares them there.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_BEAT} bstate_t;

  // width code to bytes per beat
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // word offsets covered by a beat at offset off on a port of wb bytes
  function automatic logic [3:0] beat_span(input logic [1:0] off, input logic [2:0] wb);
    logic [3:0] s;
    for (int k = 0; k < 4; k++)
      s[k] = (k >= int'(off)) && (k < int'(off) + int'(wb));
    return s;
  endfunction

  // bus lane carrying word offset k
  function automatic logic [1:0] lane_of(input logic [1:0] k, input logic [2:0] wb,
                                         input logic big);
    logic [1:0] msk;
    logic [1:0] o;
    msk = wb[1:0] - 2'd1;
    o   = k & msk;
    return big ? (msk - o) : o;
  endfunction

  // word byte position of word offset k
  function automatic logic [1:0] pos_of(input logic [1:0] k, input logic big);
    return big ? ~k : k;
  endfunction

  // first beat offset >= start covering an enabled byte: {found, offset}
  function automatic logic [2:0] seek_beat(input logic [3:0] be, input logic [2:0] start,
                                           input logic [2:0] wb);
    logic [2:0] r;
    r = 3'b000;
    for (int j = 0; j < 4; j++) begin
      int c;
      c = int'(start) + j * int'(wb);
      if (!r[2] && c < 4)
        if ((be & beat_span(2'(c), wb)) != 4'b0)
          r = {1'b1, 2'(c)};
    end
    return r;
  endfunction

endpackage

// File: rtl/pwb_region_dec.sv
module pwb_region_dec #(
  parameter int NREG   = 4,
  parameter int TAG_W  = 4,
  parameter int WAIT_W = 3,
  localparam int IDX_W = $clog2(NREG + 1)
) (
  input  logic [TAG_W-1:0]       addr_tag,
  input  logic [NREG*TAG_W-1:0]  cfg_tag,
  input  logic [NREG*2-1:0]      cfg_width,
  input  logic [NREG*WAIT_W-1:0] cfg_wait,
  output logic [IDX_W-1:0]       hit_idx,
  output logic [1:0]             hit_wcode,
  output logic [WAIT_W-1:0]      hit_wait
);
  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_match
    assign hit[i] = (cfg_tag[i*TAG_W +: TAG_W] == addr_tag);
  end

  always_comb begin
    hit_idx   = IDX_W'(NREG);
    hit_wcode = 2'd2;
    hit_wait  = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx   = IDX_W'(i);
        hit_wcode = cfg_width[i*2 +: 2];
        hit_wait  = cfg_wait[i*WAIT_W +: WAIT_W];
      end
    end
  end
endmodule

// File: rtl/pwb_beat_seq.sv
module pwb_beat_seq
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WAIT_W      = 3,
  parameter int TURN_W      = 4,
  parameter int BURST_WORDS = 4,
  parameter int IDX_W       = 3,
  localparam int WIDX_W     = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic [1:0]        dec_wcode,
  input  logic [WAIT_W-1:0] dec_wait,
  input  logic [TURN_W-1:0] cfg_turn,
  output logic              req_ready,
  output logic              accept,
  output logic              in_gap,
  output logic              in_beat,
  output logic              beat_end,
  output logic              word_end,
  output logic              txn_done,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cur_off,
  output logic [2:0]        cur_wb,
  output logic [3:0]        cur_be
);
  bstate_t           st;
  logic [ADDR_W-1:0] t_base;
  logic              t_burst;
  logic [WAIT_W-1:0] t_wait;
  logic [WAIT_W-1:0] wcnt;
  logic [TURN_W-1:0] gcnt;
  logic [WIDX_W-1:0] widx;
  logic              prev_rd;
  logic [IDX_W-1:0]  prev_idx;

  logic              wr_eff;
  logic [3:0]        be_in;
  logic [2:0]        wb_in;
  logic [2:0]        first;
  logic [2:0]        nxt;
  logic              need_gap;
  logic              last_word;

  assign wr_eff    = req_write && !req_burst;
  assign be_in     = req_burst ? 4'hF : req_be;
  assign wb_in     = width_bytes(dec_wcode);
  assign first     = seek_beat(be_in, 3'd0, wb_in);
  assign need_gap  = prev_rd && (wr_eff || dec_idx != prev_idx) && (cfg_turn != '0);

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign in_gap    = (st == ST_GAP);
  assign in_beat   = (st == ST_BEAT);
  assign beat_end  = in_beat && (wcnt == t_wait);
  assign nxt       = seek_beat(cur_be, {1'b0, cur_off} + cur_wb, cur_wb);
  assign word_end  = beat_end && !nxt[2];
  assign last_word = !t_burst || (widx == WIDX_W'(BURST_WORDS - 1));
  assign txn_done  = word_end && last_word;
  assign cur_addr  = t_base + (ADDR_W'(widx) << 2) + ADDR_W'(cur_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      t_base    <= '0;
      t_burst   <= 1'b0;
      t_wait    <= '0;
      wcnt      <= '0;
      gcnt      <= '0;
      widx      <= '0;
      prev_rd   <= 1'b0;
      prev_idx  <= '0;
      cur_write <= 1'b0;
      cur_off   <= '0;
      cur_wb    <= 3'd4;
      cur_be    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          t_base    <= req_addr & ~ADDR_W'(3);
          t_burst   <= req_burst;
          t_wait    <= dec_wait;
          cur_write <= wr_eff;
          cur_wb    <= wb_in;
          cur_be    <= be_in;
          cur_off   <= first[1:0];
          wcnt      <= '0;
          widx      <= '0;
          gcnt      <= cfg_turn;
          prev_rd   <= !wr_eff;
          prev_idx  <= dec_idx;
          st        <= need_gap ? ST_GAP : ST_BEAT;
        end
        ST_GAP: begin
          if (gcnt <= TURN_W'(1)) st <= ST_BEAT;
          else                    gcnt <= gcnt - TURN_W'(1);
        end
        ST_BEAT: begin
          if (beat_end) begin
            wcnt <= '0;
            if (nxt[2]) cur_off <= nxt[1:0];
            else if (last_word) st <= ST_IDLE;
            else begin
              widx    <= widx + WIDX_W'(1);
              cur_off <= 2'd0;
            end
          end else begin
            wcnt <= wcnt + WAIT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwb_lane_steer.sv
module pwb_lane_steer
  import pwb_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [1:0]        off,
  input  logic [2:0]        wb,
  input  logic [LANES-1:0]  be,
  input  logic              big,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] acc,
  output logic [LANES-1:0]  lane_be,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [DATA_W-1:0] acc_next
);
  logic [3:0]       span;
  logic [LANES-1:0] take;
  logic [1:0]       lane [LANES];
  logic [1:0]       pos  [LANES];

  assign span = beat_span(off, wb);

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign take[k] = span[k] && be[k];
    assign lane[k] = lane_of(2'(k), wb, big);
    assign pos[k]  = pos_of(2'(k), big);
  end

  always_comb begin
    lane_be    = '0;
    lane_wdata = '0;
    acc_next   = acc;
    for (int k = 0; k < LANES; k++) begin
      if (take[k]) begin
        lane_be[lane[k]]             = 1'b1;
        lane_wdata[lane[k]*8 +: 8]   = wdata[pos[k]*8 +: 8];
        acc_next[pos[k]*8 +: 8]      = rdata[lane[k]*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/pwbus_bridge.sv
module pwbus_bridge
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NREG        = 4,
  parameter int TAG_W       = 4,
  parameter int WAIT_W      = 3,
  parameter int TURN_W      = 4,
  parameter int BURST_WORDS = 4,
  localparam int LANES      = DATA_W / 8,
  localparam int IDX_W      = $clog2(NREG + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_burst,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [LANES-1:0]       req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic [NREG*TAG_W-1:0]  cfg_tag,
  input  logic [NREG*2-1:0]      cfg_width,
  input  logic [NREG*WAIT_W-1:0] cfg_wait,
  input  logic [TURN_W-1:0]      cfg_turn,
  input  logic                   cfg_bigend,
  output logic                   bus_valid,
  output logic                   bus_write,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [LANES-1:0]       bus_be,
  output logic [DATA_W-1:0]      bus_wdata,
  input  logic [DATA_W-1:0]      bus_rdata
);
  logic [IDX_W-1:0]  dec_idx;
  logic [1:0]        dec_wcode;
  logic [WAIT_W-1:0] dec_wait;
  logic              accept, in_gap, in_beat, beat_end, word_end, txn_done, cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        cur_off;
  logic [2:0]        cur_wb;
  logic [3:0]        cur_be;
  logic [DATA_W-1:0] t_wdata, acc, acc_next, lane_wdata;
  logic [LANES-1:0]  lane_be;

  pwb_region_dec #(.NREG(NREG), .TAG_W(TAG_W), .WAIT_W(WAIT_W)) u_dec (
    .addr_tag (req_addr[ADDR_W-1 -: TAG_W]),
    .cfg_tag  (cfg_tag),
    .cfg_width(cfg_width),
    .cfg_wait (cfg_wait),
    .hit_idx  (dec_idx),
    .hit_wcode(dec_wcode),
    .hit_wait (dec_wait)
  );

  pwb_beat_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .TURN_W(TURN_W),
                 .BURST_WORDS(BURST_WORDS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
    .req_addr(req_addr), .req_be(req_be),
    .dec_idx(dec_idx), .dec_wcode(dec_wcode), .dec_wait(dec_wait), .cfg_turn(cfg_turn),
    .req_ready(req_ready), .accept(accept), .in_gap(in_gap), .in_beat(in_beat),
    .beat_end(beat_end), .word_end(word_end), .txn_done(txn_done),
    .cur_write(cur_write), .cur_addr(cur_addr), .cur_off(cur_off),
    .cur_wb(cur_wb), .cur_be(cur_be)
  );

  pwb_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .off(cur_off), .wb(cur_wb), .be(cur_be), .big(cfg_bigend),
    .wdata(t_wdata), .rdata(bus_rdata), .acc(acc),
    .lane_be(lane_be), .lane_wdata(lane_wdata), .acc_next(acc_next)
  );

  assign bus_valid = in_beat;
  assign bus_write = in_beat && cur_write;
  assign bus_addr  = in_beat ? cur_addr : '0;
  assign bus_be    = in_beat ? lane_be : '0;
  assign bus_wdata = (in_beat && cur_write) ? lane_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_wdata   <= '0;
      acc       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) t_wdata <= req_wdata;
      rsp_valid <= word_end;
      if (word_end) begin
        rsp_rdata <= cur_write ? '0 : acc_next;
        acc       <= '0;
      end else if (beat_end) begin
        acc <= acc_next;
      end
    end
  end
endmodule

// File: rtl/pwbus_bridge_chk.sv
module pwbus_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_be,
  input logic              in_gap,
  input logic              beat_end,
  input logic              word_end,
  input logic [2:0]        cur_wb
);
  logic [3:0] port_mask;
  assign port_mask = (cur_wb == 3'd1) ? 4'b0001 : (cur_wb == 3'd2) ? 4'b0011 : 4'b1111;

  AST_GAP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> !bus_valid); // R10
  AST_IDLE_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid); // R11
  AST_LANES_IN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_be & ~port_mask) == 4'b0)); // R5
  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_addr[1:0] & (cur_wb[1:0] - 2'd1)) == 2'b0)); // R3
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_be != 4'b0)); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !beat_end) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be))); // R8
  AST_RSP_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> rsp_valid); // R7
endmodule

bind pwbus_bridge pwbus_bridge_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be(bus_be),
  .in_gap(in_gap), .beat_end(beat_end), .word_end(word_end), .cur_wb(cur_wb)
);

// File: tb/tb_pwbus_bridge.sv
`timescale 1ns/1ps
module tb_pwbus_bridge;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_burst;
  logic [31:0] req_addr, req_wdata, rsp_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  req_be, bus_be, cfg_turn;
  logic        rsp_valid, cfg_bigend, bus_valid, bus_write;
  logic [15:0] cfg_tag;
  logic [7:0]  cfg_width;
  logic [11:0] cfg_wait;

  int vecs = 0, bad = 0;
  bit done = 0;
  int tg[4] = '{1, 2, 3, 1};
  int wc[4] = '{0, 1, 2, 2};
  int wt[4] = '{0, 1, 2, 0};
  int turn = 2;
  bit big = 0;
  bit prev_rd = 0;
  int prev_idx = 0;

  typedef struct {
    logic v; logic [31:0] a; logic [3:0] be; logic w; logic [31:0] wd;
    logic rv; logic [31:0] rd; logic rdy;
  } cyc_t;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      cfg_tag[i*4 +: 4]   = 4'(tg[i]);
      cfg_width[i*2 +: 2] = 2'(wc[i]);
      cfg_wait[i*3 +: 3]  = 3'(wt[i]);
    end
  end
  assign cfg_turn   = 4'(turn);
  assign cfg_bigend = big;

  pwbus_bridge dut (.*);

  function automatic int memf(input logic [31:0] a);
    return int'(((a * 13 + 5) ^ (a >> 8)) & 32'hFF);
  endfunction

  function automatic void region(input logic [31:0] a, output int idx, output int wb,
                                 output int ws);
    idx = 4; wb = 4; ws = 0;
    for (int i = 3; i >= 0; i--) if (a[31:28] == 4'(tg[i])) idx = i;
    if (idx < 4) begin
      wb = (wc[idx] == 0) ? 1 : (wc[idx] == 1) ? 2 : 4;
      ws = wt[idx];
    end
  endfunction

  // bus slave: fills the lanes of the addressed port from memf
  always_comb begin
    int ri, rw, rs;
    bus_rdata = 32'hEEEE_EEEE;
    if (bus_valid && !bus_write) begin
      region(bus_addr, ri, rw, rs);
      for (int o = 0; o < rw; o++) begin
        int l;
        l = big ? (rw - 1 - o) : o;
        bus_rdata[l*8 +: 8] = 8'(memf(bus_addr + 32'(o)));
      end
    end
  end

  task automatic compare(input cyc_t r, input string tag, input int i);
    bit mis;
    vecs++;
    mis = (bus_valid !== r.v) || (req_ready !== r.rdy) || (rsp_valid !== r.rv);
    if (r.v) begin
      if (bus_addr !== r.a || bus_be !== r.be || bus_write !== r.w) mis = 1;
      if (r.w && bus_wdata !== r.wd) mis = 1;
    end
    if (r.rv && rsp_rdata !== r.rd) mis = 1;
    if (mis) begin
      bad++;
      $display("FAIL %s cyc%0d: got v=%b a=%h be=%b w=%b wd=%h rv=%b rd=%h rdy=%b exp v=%b a=%h be=%b w=%b wd=%h rv=%b rd=%h rdy=%b",
               tag, i, bus_valid, bus_addr, bus_be, bus_write, bus_wdata, rsp_valid,
               rsp_rdata, req_ready, r.v, r.a, r.be, r.w, r.wd, r.rv, r.rd, r.rdy);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input bit bst, input string tag);
    cyc_t q[$];
    cyc_t blank, r;
    int idx, wb, ws, gap, nw;
    bit weff, pend;
    logic [31:0] prd;
    blank = '{v:0, a:0, be:0, w:0, wd:0, rv:0, rd:0, rdy:0};
    region(a, idx, wb, ws);
    weff = wr && !bst;
    gap = (prev_rd && (weff || idx != prev_idx)) ? turn : 0;
    prev_rd = !weff;
    prev_idx = idx;
    for (int g = 0; g < gap; g++) q.push_back(blank);
    nw = bst ? 4 : 1;
    pend = 0;
    prd = 0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] base, wordv;
      logic [3:0] eb;
      base = {a[31:2], 2'b00} + 32'(w * 4);
      eb = bst ? 4'hF : be;
      wordv = 0;
      for (int k = 0; k < 4; k++) begin
        int p;
        p = big ? 3 - k : k;
        if (eb[k]) wordv[p*8 +: 8] = 8'(memf(base + 32'(k)));
      end
      for (int off = 0; off < 4; off += wb) begin
        logic [3:0] lbe;
        logic [31:0] lwd;
        bit any;
        lbe = 0; lwd = 0; any = 0;
        for (int k = off; k < off + wb; k++) begin
          if (eb[k]) begin
            int l, p;
            any = 1;
            l = big ? (wb - 1 - (k - off)) : (k - off);
            p = big ? 3 - k : k;
            lbe[l] = 1'b1;
            lwd[l*8 +: 8] = wd[p*8 +: 8];
          end
        end
        if (any) begin
          for (int c = 0; c <= ws; c++) begin
            r = blank;
            r.v = 1; r.a = base + 32'(off); r.be = lbe; r.w = weff; r.wd = lwd;
            if (pend) begin r.rv = 1; r.rd = prd; pend = 0; end
            q.push_back(r);
          end
        end
      end
      pend = 1;
      prd = weff ? 32'h0 : wordv;
    end
    r = blank;
    r.rv = pend; r.rd = prd; r.rdy = 1;
    q.push_back(r);

    // R11: ready must be up when offering the request
    vecs++;
    if (req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R11 %s: req_ready got %b exp 1", tag, req_ready);
    end
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_burst = bst;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0; req_burst = 0; req_be = 0; req_wdata = 32'hDEAD_BEEF;
    for (int i = 0; i < q.size(); i++) begin
      compare(q[i], tag, i);
      if (i < q.size() - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_burst = 0;
    req_addr = 0; req_be = 0; req_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    vecs++;
    if (req_ready !== 1 || bus_valid !== 0 || rsp_valid !== 0) begin
      bad++;
      $display("FAIL R1: got rdy=%b bv=%b rv=%b exp 1 0 0", req_ready, bus_valid, rsp_valid);
    end
    @(negedge clk);

    run_txn(1, 32'h3000_0010, 4'hF, 32'hA1B2_C3D4, 0, "R6 R8 word write 32-bit port");
    run_txn(0, 32'h3000_0010, 4'hF, 32'h0, 0, "R7 R8 word read 32-bit port");
    run_txn(0, 32'h1000_0020, 4'hF, 32'h0, 0, "R2 R3 R10 byte port after read");
    run_txn(0, 32'h1000_0024, 4'b1100, 32'h0, 0, "R4 upper half on byte port");
    run_txn(1, 32'h2000_0040, 4'hF, 32'h1122_3344, 0, "R3 R6 R10 halfword port write");
    big = 1;
    run_txn(0, 32'h2000_0040, 4'hF, 32'h0, 0, "R5 R12 big-endian halfword port");
    run_txn(1, 32'h1000_0031, 4'b0010, 32'h55AA_66BB, 0, "R5 R6 R12 big-endian byte write");
    run_txn(0, 32'h2000_0106, 4'b0001, 32'h0, 1, "R9 R12 burst on halfword port");
    big = 0;
    run_txn(1, 32'h5000_0008, 4'b0001, 32'h0, 1, "R2 R9 R10 burst unmatched region");
    turn = 0;
    run_txn(0, 32'h3000_0000, 4'b0110, 32'h0, 0, "R10 zero turnaround");
    turn = 3;
    run_txn(0, 32'h1000_0002, 4'b0100, 32'h0, 0, "R4 R10 single byte after gap");
    run_txn(0, 32'h1000_0008, 4'b1001, 32'h0, 0, "R4 R11 back-to-back same region");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule